// File: doc/BRIEF.md
# Job-Triggered Power Domain Sequencer

This block controls power for an accelerator that has one base domain (control and front-end logic) and a configurable number of compute-cluster domains, four by default. At reset, and whenever it has been idle long enough with gating allowed, every domain is switched off. There is no powered idle state with only the clock stopped. The first job request wakes the block in a fixed order. The base domain is enabled first, and the block waits for its power-good. It then enables each compute set in ascending order, waiting for each power-good in turn. Isolation is released only after that, and only then does the block offer the job for dispatch.

When dynamic gating is on, an idle counter starts at the completion of the last job. When the count reaches a first limit, the compute sets are taken down in descending order, each one clamped before its enable is removed. When the count reaches a second, longer limit, the base domain is removed as well. A request that arrives during a power-down lets the step in progress finish, then powers the sets back up. When dynamic gating is off, the compute sets stay powered and the next job is accepted at once. Each power-up wait has a timeout. If power-good never arrives, the block sets a sticky error flag and drops back to all-off.

Power-good inputs are synchronised inside the block. A job is accepted in any cycle where both `job_req` and `job_ready` are high.

Top module: `job_power_seq`

## Requirements
- R1: During and after reset, `base_pwr_en` is 0, `cset_pwr_en` is all 0, `cset_pwr_iso` is all 1 (1 means clamped), `job_ready` is 0 and `pwr_err` is 0.
- R2: While every domain is off and no job is requested, no enable is raised.
- R3: A request from all-off enables the base domain first. No compute-set enable is high unless the base enable is high. Compute sets are enabled only after the base power-good has been seen.
- R4: `job_ready` is high only when the base enable and all compute-set enables are high and no set is clamped. After a job is accepted, `job_ready` stays low until `job_done`.
- R5: A compute set whose enable is low is always clamped. Enables rise in ascending set order. Power-down clamps a set before removing its enable, working from the highest set to set 0.
- R6: With dynamic gating on, once the idle count since the last `job_done` reaches `cset_idle_limit`, all compute sets are gated off and clamped while the base domain stays on.
- R7: With dynamic gating on, once the idle count reaches `base_idle_limit`, the base enable is removed. The base enable never falls while any compute-set enable is high.
- R8: With dynamic gating off, an idle ready block keeps all domains powered and stays ready indefinitely, so the next job is accepted in the cycle it is requested.
- R9: A request that arrives during a compute power-down ends with every domain powered, no set clamped and the job accepted.
- R10: If power-good is not seen within `WAIT_LIMIT` cycles of a power-up step, `pwr_err` is set and stays set until reset. All enables are dropped, all sets are clamped, and that request is not made ready.
- R11: A request that finds the block fully gated off is not ready in the cycle it arrives and pays the full wake sequence. A request that arrives while the block is ready is accepted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dyn_gate_en | input | 1 | 1 allows idle gating of the domains |
| cset_idle_limit | input | IDLE_W | Idle cycles before the compute sets are gated |
| base_idle_limit | input | IDLE_W | Idle cycles before the base domain is gated |
| job_req | input | 1 | Job request |
| job_ready | output | 1 | Block fully powered and able to accept a job |
| job_done | input | 1 | Pulse marking the end of the running job |
| base_pwr_en | output | 1 | Base domain enable |
| base_pwr_good | input | 1 | Base domain power-good (asynchronous) |
| cset_pwr_en | output | N_CSET | Compute-set enables, bit k is set k |
| cset_pwr_good | input | N_CSET | Compute-set power-good (asynchronous) |
| cset_pwr_iso | output | N_CSET | Compute-set clamps, 1 means clamped |
| pwr_err | output | 1 | Sticky power-up timeout flag |

## Verification
The checker enforces, on every cycle, the structural rules of the block. The base enable must cover every compute enable, and a set whose enable is low must be clamped. Enables must rise in ascending order and fall only after the clamp. The base must come down only after all sets. Ready must imply full power, the block must stay off without a request, ready must hold when gating is off, and the error flag must be sticky. Other properties depend on long sequences and are shown only by the bench's scenarios. These are: the idle-count points where gating starts, whether a request pays the wake sequence or is accepted at once, recovery from a request that interrupts power-down, and the timeout with a stuck power-good.

// File: rtl/jps_pkg.sv
package jps_pkg;

    typedef enum logic [3:0] {
        ST_OFF,
        ST_BASE_WAIT,
        ST_CSET_UP,
        ST_UNCLAMP,
        ST_READY,
        ST_BUSY,
        ST_DOWN_ISO,
        ST_DOWN_OFF,
        ST_BASE_IDLE
    } seq_state_t;

endpackage

// File: rtl/jps_sync.sv
module jps_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/jps_sat_counter.sv
module jps_sat_counter #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [WIDTH-1:0] count
);
    logic [WIDTH-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)                          cnt_d = '0;
        else if (inc && (cnt_q != '1))    cnt_d = cnt_q + WIDTH'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/job_power_seq.sv
module job_power_seq
    import jps_pkg::*;
#(
    parameter int N_CSET      = 4,
    parameter int IDLE_W      = 16,
    parameter int WAIT_LIMIT  = 256,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dyn_gate_en,
    input  logic [IDLE_W-1:0] cset_idle_limit,
    input  logic [IDLE_W-1:0] base_idle_limit,
    input  logic              job_req,
    output logic              job_ready,
    input  logic              job_done,
    output logic              base_pwr_en,
    input  logic              base_pwr_good,
    output logic [N_CSET-1:0] cset_pwr_en,
    input  logic [N_CSET-1:0] cset_pwr_good,
    output logic [N_CSET-1:0] cset_pwr_iso,
    output logic              pwr_err
);
    localparam int IDX_W  = (N_CSET > 1) ? $clog2(N_CSET) : 1;
    localparam int WAIT_W = $clog2(WAIT_LIMIT + 1);
    localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(N_CSET - 1);
    localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(WAIT_LIMIT);

    typedef struct packed {
        seq_state_t        st;
        logic [IDX_W-1:0]  idx;
        logic              base_en;
        logic [N_CSET-1:0] en;
        logic [N_CSET-1:0] iso;
        logic              err;
    } seq_regs_t;

    seq_regs_t cur_q, nxt_d;

    logic              base_good_s;
    logic [N_CSET-1:0] cset_good_s;
    logic [WAIT_W-1:0] wait_cnt;
    logic [IDLE_W-1:0] idle_cnt;
    logic              wait_clr, wait_inc;
    logic              idle_clr, idle_inc;
    logic              step_adv;

    jps_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_base_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (base_pwr_good),
        .dout (base_good_s)
    );

    jps_sync #(.WIDTH(N_CSET), .STAGES(SYNC_STAGES)) u_cset_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (cset_pwr_good),
        .dout (cset_good_s)
    );

    jps_sat_counter #(.WIDTH(WAIT_W)) u_wait_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (wait_clr),
        .inc  (wait_inc),
        .count(wait_cnt)
    );

    jps_sat_counter #(.WIDTH(IDLE_W)) u_idle_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (idle_clr),
        .inc  (idle_inc),
        .count(idle_cnt)
    );

    always_comb begin
        nxt_d    = cur_q;
        step_adv = 1'b0;

        wait_inc = (cur_q.st == ST_BASE_WAIT) || (cur_q.st == ST_CSET_UP);
        idle_inc = (cur_q.st == ST_READY)    || (cur_q.st == ST_DOWN_ISO) ||
                   (cur_q.st == ST_DOWN_OFF) || (cur_q.st == ST_BASE_IDLE);

        unique case (cur_q.st)
            ST_OFF: begin
                if (job_req) begin
                    nxt_d.st      = ST_BASE_WAIT;
                    nxt_d.base_en = 1'b1;
                end
            end

            ST_BASE_WAIT: begin
                if (base_good_s) begin
                    step_adv        = 1'b1;
                    nxt_d.st        = ST_CSET_UP;
                    nxt_d.idx       = '0;
                    nxt_d.en[0]     = 1'b1;
                end else if (wait_cnt >= WAIT_LAST) begin
                    nxt_d.st      = ST_OFF;
                    nxt_d.base_en = 1'b0;
                    nxt_d.en      = '0;
                    nxt_d.iso     = '1;
                    nxt_d.err     = 1'b1;
                end
            end

            ST_CSET_UP: begin
                if (cset_good_s[cur_q.idx]) begin
                    step_adv = 1'b1;
                    if (cur_q.idx == LAST_IDX) begin
                        nxt_d.st  = ST_UNCLAMP;
                        nxt_d.iso = '0;
                    end else begin
                        nxt_d.idx                  = cur_q.idx + IDX_W'(1);
                        nxt_d.en[cur_q.idx + IDX_W'(1)] = 1'b1;
                    end
                end else if (wait_cnt >= WAIT_LAST) begin
                    nxt_d.st      = ST_OFF;
                    nxt_d.base_en = 1'b0;
                    nxt_d.en      = '0;
                    nxt_d.iso     = '1;
                    nxt_d.err     = 1'b1;
                end
            end

            ST_UNCLAMP: begin
                nxt_d.st = ST_READY;
            end

            ST_READY: begin
                if (job_req) begin
                    nxt_d.st = ST_BUSY;
                end else if (dyn_gate_en && (idle_cnt >= cset_idle_limit)) begin
                    nxt_d.st            = ST_DOWN_ISO;
                    nxt_d.idx           = LAST_IDX;
                    nxt_d.iso[LAST_IDX] = 1'b1;
                end
            end

            ST_BUSY: begin
                if (job_done) nxt_d.st = ST_READY;
            end

            ST_DOWN_ISO: begin
                if (job_req) begin
                    nxt_d.st    = ST_CSET_UP;
                    nxt_d.idx   = '0;
                    nxt_d.en[0] = 1'b1;
                end else begin
                    nxt_d.st            = ST_DOWN_OFF;
                    nxt_d.en[cur_q.idx] = 1'b0;
                end
            end

            ST_DOWN_OFF: begin
                if (job_req) begin
                    nxt_d.st    = ST_CSET_UP;
                    nxt_d.idx   = '0;
                    nxt_d.en[0] = 1'b1;
                end else if (cur_q.idx == '0) begin
                    nxt_d.st = ST_BASE_IDLE;
                end else begin
                    nxt_d.st                         = ST_DOWN_ISO;
                    nxt_d.idx                        = cur_q.idx - IDX_W'(1);
                    nxt_d.iso[cur_q.idx - IDX_W'(1)] = 1'b1;
                end
            end

            ST_BASE_IDLE: begin
                if (job_req) begin
                    nxt_d.st    = ST_CSET_UP;
                    nxt_d.idx   = '0;
                    nxt_d.en[0] = 1'b1;
                end else if (dyn_gate_en && (idle_cnt >= base_idle_limit)) begin
                    nxt_d.st      = ST_OFF;
                    nxt_d.base_en = 1'b0;
                end
            end

            default: begin
                nxt_d.st      = ST_OFF;
                nxt_d.base_en = 1'b0;
                nxt_d.en      = '0;
                nxt_d.iso     = '1;
            end
        endcase

        wait_clr = !wait_inc || step_adv;
        idle_clr = !idle_inc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.st      <= ST_OFF;
            cur_q.idx     <= '0;
            cur_q.base_en <= 1'b0;
            cur_q.en      <= '0;
            cur_q.iso     <= '1;
            cur_q.err     <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign job_ready    = (cur_q.st == ST_READY);
    assign base_pwr_en  = cur_q.base_en;
    assign cset_pwr_en  = cur_q.en;
    assign cset_pwr_iso = cur_q.iso;
    assign pwr_err      = cur_q.err;
endmodule

// File: rtl/jps_checker.sv
module jps_checker #(
    parameter int N_CSET = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dyn_gate_en,
    input logic              job_req,
    input logic              job_ready,
    input logic              base_pwr_en,
    input logic [N_CSET-1:0] cset_pwr_en,
    input logic [N_CSET-1:0] cset_pwr_iso,
    input logic              pwr_err
);
    // R2: with nothing requested, an all-off block stays off
    a_r2_stay_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!base_pwr_en && !job_req) |=> !base_pwr_en);

    // R3: no compute set is enabled without the base domain
    a_r3_base_covers: assert property (@(posedge clk) disable iff (!rst_n)
        (|cset_pwr_en) |-> base_pwr_en);

    // R4: ready only at full, unclamped power
    a_r4_ready_full: assert property (@(posedge clk) disable iff (!rst_n)
        job_ready |-> (base_pwr_en && (&cset_pwr_en) && (cset_pwr_iso == '0)));

    // R7: base comes down only with every compute set already down
    a_r7_base_last: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(base_pwr_en) |-> (cset_pwr_en == '0));

    // R8: static mode keeps an idle ready block ready
    a_r8_hold_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (job_ready && !dyn_gate_en && !job_req) |=> job_ready);

    // R10: the error flag is sticky and comes with all-off
    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_err |=> pwr_err);
    a_r10_err_off: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_err) |-> (!base_pwr_en && (cset_pwr_en == '0) && !job_ready));

    generate
        for (genvar k = 0; k < N_CSET; k++) begin : g_set
            // R5: an unpowered set is clamped
            a_r5_iso_when_off: assert property (@(posedge clk) disable iff (!rst_n)
                !cset_pwr_en[k] |-> cset_pwr_iso[k]);
            // R5: the clamp was already on before the enable fell
            a_r5_clamp_first: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(cset_pwr_en[k]) |-> $past(cset_pwr_iso[k]));
            if (k > 0) begin : g_order
                // R5: ascending enable order
                a_r5_up_order: assert property (@(posedge clk) disable iff (!rst_n)
                    $rose(cset_pwr_en[k]) |-> $past(cset_pwr_en[k-1]));
            end
        end
    endgenerate
endmodule

bind job_power_seq jps_checker #(.N_CSET(N_CSET)) u_jps_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .dyn_gate_en (dyn_gate_en),
    .job_req     (job_req),
    .job_ready   (job_ready),
    .base_pwr_en (base_pwr_en),
    .cset_pwr_en (cset_pwr_en),
    .cset_pwr_iso(cset_pwr_iso),
    .pwr_err     (pwr_err)
);

// File: tb/job_power_seq_bench.sv
module job_power_seq_bench;
    localparam int N    = 4;
    localparam int IW   = 16;
    localparam int WLIM = 16;
    localparam int GD   = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dyn_gate_en = 1'b1;
    logic [IW-1:0] cset_idle_limit = 16'd1000;
    logic [IW-1:0] base_idle_limit = 16'd2000;
    logic          job_req = 1'b0;
    logic          job_done = 1'b0;
    logic          job_ready, base_pwr_en, pwr_err;
    logic          base_pwr_good;
    logic [N-1:0]  cset_pwr_en, cset_pwr_good, cset_pwr_iso;
    logic [N-1:0]  stuck = '0;

    logic [GD-1:0] base_dly;
    logic [N-1:0]  cset_dly [GD];

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    job_power_seq #(.N_CSET(N), .IDLE_W(IW), .WAIT_LIMIT(WLIM), .SYNC_STAGES(2)) u_job_power_seq (
        .clk(clk), .rst_n(rst_n), .dyn_gate_en(dyn_gate_en),
        .cset_idle_limit(cset_idle_limit), .base_idle_limit(base_idle_limit),
        .job_req(job_req), .job_ready(job_ready), .job_done(job_done),
        .base_pwr_en(base_pwr_en), .base_pwr_good(base_pwr_good),
        .cset_pwr_en(cset_pwr_en), .cset_pwr_good(cset_pwr_good),
        .cset_pwr_iso(cset_pwr_iso), .pwr_err(pwr_err)
    );

    // Domain model: power-good follows the enable after GD cycles
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_dly <= '0;
            for (int i = 0; i < GD; i++) cset_dly[i] <= '0;
        end else begin
            base_dly <= {base_dly[GD-2:0], base_pwr_en};
            cset_dly[0] <= cset_pwr_en;
            for (int i = 1; i < GD; i++) cset_dly[i] <= cset_dly[i-1];
        end
    end
    assign base_pwr_good = base_dly[GD-1];
    assign cset_pwr_good = cset_dly[GD-1] & ~stuck;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit expect_now(input bit dyn, input int gap, input int cthr);
        return (!dyn) || (gap < cthr - 2);
    endfunction

    // Request a job, check readiness on arrival, wait for acceptance
    task automatic run_job(input bit exp_now, input string tag, input int busy);
        bit order_bad = 0;
        int n = 0;
        @(negedge clk);
        job_req = 1'b1;
        check(job_ready == exp_now, tag, job_ready, exp_now);
        while (!job_ready && n < 300) begin
            @(negedge clk);
            if ((|cset_pwr_en) && !base_pwr_en) order_bad = 1;
            n++;
        end
        check(!order_bad, "R3 base before compute", order_bad, 0);
        check(job_ready, "R4 job reaches ready", job_ready, 1);
        check(base_pwr_en && (&cset_pwr_en) && (cset_pwr_iso == '0),
              "R4 full power at ready", int'(cset_pwr_en), (1 << N) - 1);
        @(negedge clk);
        job_req = 1'b0;
        check(!job_ready, "R4 busy after accept", job_ready, 0);
        repeat (busy) @(negedge clk);
        job_done = 1'b1;
        @(negedge clk);
        job_done = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1 reset values
        check(!base_pwr_en && cset_pwr_en == '0 && cset_pwr_iso == '1 && !job_ready && !pwr_err,
              "R1 reset state", int'(cset_pwr_iso), (1 << N) - 1);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        check(!base_pwr_en && cset_pwr_en == '0, "R2 idle stays off", base_pwr_en, 0);

        // R11 cold start, then immediate follow-on job
        run_job(1'b0, "R11 cold request not ready", 4);
        run_job(1'b1, "R11 follow-on accepted at once", 2);

        // R6 / R7 idle gating points
        cset_idle_limit = 16'd20;
        base_idle_limit = 16'd60;
        run_job(1'b1, "R4 ready job", 3);
        repeat (17) @(negedge clk);
        check(&cset_pwr_en, "R6 no gating before limit", int'(cset_pwr_en), (1 << N) - 1);
        repeat (22) @(negedge clk);
        check(cset_pwr_en == '0 && cset_pwr_iso == '1, "R6 compute sets gated", int'(cset_pwr_en), 0);
        check(base_pwr_en, "R6 base kept on", base_pwr_en, 1);
        repeat (50) @(negedge clk);
        check(!base_pwr_en, "R7 base gated", base_pwr_en, 1'b0);
        run_job(1'b0, "R11 wake after full gate-off", 2);

        // R8 static mode
        dyn_gate_en = 1'b0;
        cset_idle_limit = 16'd5;
        base_idle_limit = 16'd10;
        repeat (100) @(negedge clk);
        check(job_ready && (&cset_pwr_en) && base_pwr_en, "R8 stays powered", int'(cset_pwr_en), (1 << N) - 1);
        run_job(1'b1, "R8 immediate accept", 1);

        // R9 request during power-down, random offsets
        dyn_gate_en = 1'b1;
        cset_idle_limit = 16'd10;
        base_idle_limit = 16'd500;
        for (int it = 0; it < 8; it++) begin
            int off = 11 + int'($urandom_range(0, 9));
            repeat (off) @(negedge clk);
            run_job(1'b0, "R9 request mid power-down", int'($urandom_range(1, 6)));
            check(cset_pwr_iso == '0, "R9 no clamp left", int'(cset_pwr_iso), 0);
        end

        // Random mix of gaps and modes
        cset_idle_limit = 16'd12;
        base_idle_limit = 16'd40;
        for (int it = 0; it < 20; it++) begin
            bit dyn = bit'($urandom_range(0, 1));
            int gap = ($urandom_range(0, 1) != 0) ? int'($urandom_range(0, 9))
                                                  : int'($urandom_range(60, 80));
            dyn_gate_en = dyn;
            repeat (gap) @(negedge clk);
            run_job(expect_now(dyn, gap, 12), "R11 wake cost vs idle gap", int'($urandom_range(1, 5)));
            dyn_gate_en = 1'b0;
        end

        // R10 timeout with compute set 2 stuck
        dyn_gate_en = 1'b1;
        cset_idle_limit = 16'd4;
        base_idle_limit = 16'd10;
        repeat (40) @(negedge clk);
        check(!base_pwr_en, "R7 all off before timeout test", base_pwr_en, 0);
        stuck = 4'b0100;
        begin
            bit saw_ready = 0;
            int n = 0;
            @(negedge clk);
            job_req = 1'b1;
            while (!pwr_err && n < 200) begin
                @(negedge clk);
                if (job_ready) saw_ready = 1;
                n++;
            end
            job_req = 1'b0;
            check(pwr_err, "R10 error raised", pwr_err, 1);
            check(!saw_ready, "R10 no ready on failure", saw_ready, 0);
            check(!base_pwr_en && cset_pwr_en == '0 && cset_pwr_iso == '1,
                  "R10 back to all-off", int'(cset_pwr_en), 0);
        end
        stuck = '0;
        repeat (10) @(negedge clk);
        run_job(1'b0, "R10 retry after error", 2);
        check(pwr_err, "R10 error sticky", pwr_err, 1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", fails, checks);
        $finish;
    end
endmodule